// File: doc/BRIEF.md
# Lockable Two-Way Cache Tag Controller

This block holds the tag side of a small two-way set-associative cache. It keeps an address tag, a valid flag and a lock flag for every line, and one least-recently-used flag for every set. A lookup address is split into offset, set index and tag. The block answers combinationally with a hit flag and a way number. On a miss, it names the way that a fill would replace. An asserted fill strobe in the same cycle installs the new tag at the next clock edge.

Mode control comes from a small configuration register. The register holds an enable, a diagnostic test mode, a per-line lock mode and a whole-cache lock, plus a self-clearing flush command. When line-lock mode is on, every line filled during that time becomes pinned. When the global lock is on, nothing is replaced. When neither way of a set can be replaced, a miss does not allocate and the access goes to memory uncached.

In test mode the tag store works as a plain memory through a side port. The tag and lock fields can be written there. The valid and LRU flags can only be read.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every configuration field reads 0 and the cache is disabled. While enable is 0, lk_hit, lk_alloc and lk_way are 0 and a fill strobe changes no state.
- R2: Configuration bits are: bit 0 enable, bit 1 test mode, bit 2 line-lock mode, bit 3 global lock, bit 4 flush. A write takes effect on the lookups of the following cycle. cfg_rdata returns bits 0 to 3 at the same positions, and bit 4 always reads 0.
- R3: A lookup whose tag equals the tag of a valid way in the selected set gives lk_hit=1 and lk_way equal to that way. If both ways match, way 0 is reported.
- R4: On a miss with enable=1, test=0 and global lock=0, lk_alloc=1 when at least one way of the set is unlocked. The victim is the LRU way if neither way is locked, otherwise the unlocked way. A fill strobe in that cycle makes the victim valid and gives it the lookup tag.
- R5: When both ways of the set are locked, or global lock is 1, a miss gives lk_alloc=0 and lk_way=0, and a fill strobe changes no state.
- R6: A fill writes the line's lock flag with the line-lock mode bit of that cycle. Lock flags persist after the mode is cleared.
- R7: The LRU flag resets to 0 (way 0). A hit on way w, or a fill into way w, sets the LRU flag of that set to the other way.
- R8: A write with bit 4 set clears every valid, lock and LRU flag at the following clock edge, taking priority over any update at that edge. Tags are kept. Lookups presented after that edge miss.
- R9: tst_rdata returns {valid, set LRU, lock, tag}, MSB to LSB, for tst_set and tst_way at all times. While test mode is 1, tst_we writes the tag and the lock flag at the next edge and leaves valid and LRU unchanged. While test mode is 0, tst_we has no effect.
- R10: While test mode is 1, lookups report lk_hit=0 and lk_alloc=0 and change no LRU or tag state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration write data |
| cfg_rdata | output | 5 | Configuration readback, flush bit always 0 |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W (16) | Lookup byte address: offset, set index, tag from LSB |
| fill_strobe | input | 1 | Install lookup tag into the victim way on a miss |
| lk_hit | output | 1 | Lookup hit |
| lk_way | output | 1 | Hit way, or victim way when allocating, else 0 |
| lk_alloc | output | 1 | Miss that can allocate a line |
| tst_we | input | 1 | Test port write strobe |
| tst_set | input | IDX_W (4) | Test port set index |
| tst_way | input | 1 | Test port way |
| tst_wtag | input | TAG_W (8) | Test port tag write data |
| tst_wlock | input | 1 | Test port lock write data |
| tst_rdata | output | TAG_W+3 (11) | {valid, LRU, lock, tag} of the addressed line |

## Verification
The assertions assume the configuration register and the lookup inputs are sampled on the same clock. The victim-lock property also relies on lock flags changing only at clock edges. With those assumptions, a lock flag seen during a lookup cycle is the one the victim logic used. The directed stimulus drives every input on the falling edge and holds it through the rising edge. The random phase mixes enable, lock, test and flush writes with lookups to a small tag pool. This pool forces frequent hits, evictions and fully locked sets. Test-mode tag writes may create two matching tags in a set, and the defined way-0 priority of R3 covers that case.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int WAYS      = 2;
  localparam int CFG_W     = 5;
  // configuration bit positions (software-visible layout)
  localparam int CFG_EN    = 0;
  localparam int CFG_TEST  = 1;
  localparam int CFG_LLOCK = 2;
  localparam int CFG_GLOCK = 3;
  localparam int CFG_FLUSH = 4;

  typedef struct packed {
    logic glock;
    logic llock;
    logic test;
    logic en;
  } mode_t;
endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ctl_cfg_reg.sv
module ctl_cfg_reg
  import ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output mode_t            mode,
  output logic             flush_pulse,
  output logic [CFG_W-1:0] rd_data
);
  mode_t mode_d, mode_q;
  logic  flush_d, flush_q;

  // next state
  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      mode_d.en    = wr_data[CFG_EN];
      mode_d.test  = wr_data[CFG_TEST];
      mode_d.llock = wr_data[CFG_LLOCK];
      mode_d.glock = wr_data[CFG_GLOCK];
    end
    flush_d = wr_en & wr_data[CFG_FLUSH];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      if (wr_en) mode_q <= mode_d;
      flush_q <= flush_d;
    end
  end

  // readback: flush field is command-only and stays 0
  always_comb begin
    rd_data            = '0;
    rd_data[CFG_EN]    = mode_q.en;
    rd_data[CFG_TEST]  = mode_q.test;
    rd_data[CFG_LLOCK] = mode_q.llock;
    rd_data[CFG_GLOCK] = mode_q.glock;
  end

  assign mode        = mode_q;
  assign flush_pulse = flush_q;
endmodule

// File: rtl/ctl_way_select.sv
module ctl_way_select
  import ctl_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic [TAG_W-1:0]            req_tag,
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0]             way_lock,
  input  logic                        lru,
  input  logic                        glock,
  output logic                        hit_any,
  output logic                        hit_way,
  output logic                        vict_ok,
  output logic                        vict_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_vld[w] & (way_tag[w] == req_tag);
  end

  assign hit_any = |match;
  assign hit_way = ~match[0];          // way 0 wins a double match

  // replacement: only unlocked ways, LRU among them
  assign vict_ok = ~glock & ~(&way_lock);

  always_comb begin
    case (way_lock)
      2'b01:   vict_way = 1'b1;
      2'b10:   vict_way = 1'b0;
      default: vict_way = lru;
    endcase
  end
endmodule

// File: rtl/ctl_tag_store.sv
module ctl_tag_store
  import ctl_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  // lookup read port
  input  logic [IDX_W-1:0]           lk_set,
  output logic [WAYS-1:0]            lk_vld,
  output logic [WAYS-1:0][TAG_W-1:0] lk_tag,
  output logic [WAYS-1:0]            lk_lock,
  output logic                       lk_lru,
  // lookup-side updates
  input  logic                       fill_en,
  input  logic                       fill_way,
  input  logic [TAG_W-1:0]           fill_tag,
  input  logic                       fill_lock,
  input  logic                       upd_lru_en,
  input  logic                       upd_lru_val,
  // diagnostic port
  input  logic                       tw_en,
  input  logic [IDX_W-1:0]           tw_set,
  input  logic                       tw_way,
  input  logic [TAG_W-1:0]           tw_tag,
  input  logic                       tw_lock,
  output logic [TAG_W+2:0]           tr_data
);
  logic [SETS-1:0][WAYS-1:0]            vld_all;
  logic [SETS-1:0][WAYS-1:0]            lock_all;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_all;
  logic [SETS-1:0]                      lru_all;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    localparam logic [IDX_W-1:0] SET_ID = IDX_W'(s);

    logic [WAYS-1:0]            vld_d,  vld_q;
    logic [WAYS-1:0]            lock_d, lock_q;
    logic [WAYS-1:0][TAG_W-1:0] tag_d,  tag_q;
    logic                       lru_d,  lru_q;
    logic                       lk_sel, tw_sel, set_ce;

    assign lk_sel = (lk_set == SET_ID);
    assign tw_sel = tw_en & (tw_set == SET_ID);
    assign set_ce = flush | (lk_sel & (fill_en | upd_lru_en)) | tw_sel;

    // next state; flush overrides every other update
    always_comb begin
      vld_d  = vld_q;
      lock_d = lock_q;
      tag_d  = tag_q;
      lru_d  = lru_q;
      if (flush) begin
        vld_d  = '0;
        lock_d = '0;
        lru_d  = 1'b0;
      end else begin
        if (lk_sel && fill_en) begin
          vld_d[fill_way]  = 1'b1;
          tag_d[fill_way]  = fill_tag;
          lock_d[fill_way] = fill_lock;
        end
        if (lk_sel && upd_lru_en) lru_d = upd_lru_val;
        if (tw_sel) begin
          tag_d[tw_way]  = tw_tag;
          lock_d[tw_way] = tw_lock;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= '0;
        lock_q <= '0;
        tag_q  <= '0;
        lru_q  <= 1'b0;
      end else if (set_ce) begin
        vld_q  <= vld_d;
        lock_q <= lock_d;
        tag_q  <= tag_d;
        lru_q  <= lru_d;
      end
    end

    assign vld_all[s]  = vld_q;
    assign lock_all[s] = lock_q;
    assign tag_all[s]  = tag_q;
    assign lru_all[s]  = lru_q;
  end

  assign lk_vld  = vld_all[lk_set];
  assign lk_tag  = tag_all[lk_set];
  assign lk_lock = lock_all[lk_set];
  assign lk_lru  = lru_all[lk_set];

  assign tr_data = {vld_all[tw_set][tw_way], lru_all[tw_set],
                    lock_all[tw_set][tw_way], tag_all[tw_set][tw_way]};
endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import ctl_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 4,
  parameter int SETS   = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - OFFS_W - IDX_W,
  localparam int TRD_W = TAG_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              fill_strobe,
  output logic              lk_hit,
  output logic              lk_way,
  output logic              lk_alloc,
  input  logic              tst_we,
  input  logic [IDX_W-1:0]  tst_set,
  input  logic              tst_way,
  input  logic [TAG_W-1:0]  tst_wtag,
  input  logic              tst_wlock,
  output logic [TRD_W-1:0]  tst_rdata
);
  logic                       srst_n;
  mode_t                      mode;
  logic                       flush_pulse;
  logic [IDX_W-1:0]           lk_set;
  logic [TAG_W-1:0]           lk_tag;
  logic [WAYS-1:0]            set_vld;
  logic [WAYS-1:0][TAG_W-1:0] set_tag;
  logic [WAYS-1:0]            set_lock;
  logic                       set_lru;
  logic                       hit_any, hit_way, vict_ok, vict_way;
  logic                       active, fill_en, upd_lru_en, tw_en;

  ctl_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  ctl_cfg_reg u_cfg (
    .clk         (clk),
    .rst_n       (srst_n),
    .wr_en       (cfg_we),
    .wr_data     (cfg_wdata),
    .mode        (mode),
    .flush_pulse (flush_pulse),
    .rd_data     (cfg_rdata)
  );

  assign lk_set = lk_addr[OFFS_W +: IDX_W];
  assign lk_tag = lk_addr[ADDR_W-1 -: TAG_W];

  ctl_way_select #(.TAG_W(TAG_W)) u_sel (
    .req_tag  (lk_tag),
    .way_vld  (set_vld),
    .way_tag  (set_tag),
    .way_lock (set_lock),
    .lru      (set_lru),
    .glock    (mode.glock),
    .hit_any  (hit_any),
    .hit_way  (hit_way),
    .vict_ok  (vict_ok),
    .vict_way (vict_way)
  );

  // lookups act only when enabled and outside test mode (R1, R10)
  assign active     = mode.en & ~mode.test;
  assign lk_hit     = lk_valid & active & hit_any;
  assign lk_alloc   = lk_valid & active & ~hit_any & vict_ok;
  assign lk_way     = lk_hit ? hit_way : (lk_alloc ? vict_way : 1'b0);
  assign fill_en    = lk_alloc & fill_strobe;
  assign upd_lru_en = lk_hit | fill_en;
  assign tw_en      = tst_we & mode.test;

  ctl_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk         (clk),
    .rst_n       (srst_n),
    .flush       (flush_pulse),
    .lk_set      (lk_set),
    .lk_vld      (set_vld),
    .lk_tag      (set_tag),
    .lk_lock     (set_lock),
    .lk_lru      (set_lru),
    .fill_en     (fill_en),
    .fill_way    (vict_way),
    .fill_tag    (lk_tag),
    .fill_lock   (mode.llock),
    .upd_lru_en  (upd_lru_en),
    .upd_lru_val (~lk_way),
    .tw_en       (tw_en),
    .tw_set      (tst_set),
    .tw_way      (tst_way),
    .tw_tag      (tst_wtag),
    .tw_lock     (tst_wlock),
    .tr_data     (tst_rdata)
  );
endmodule

// File: rtl/ctl_checker.sv
module ctl_checker
  import ctl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             lk_hit,
  input logic             lk_way,
  input logic             lk_alloc,
  input logic [WAYS-1:0]  way_lock
);
  // R1: a disabled cache neither hits nor allocates
  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[CFG_EN] |-> (!lk_hit && !lk_alloc));

  // R2: the flush field never reads back as 1
  a_r2_flush_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[CFG_FLUSH]);

  // R3: hit and allocation are exclusive
  a_r3_hit_alloc_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_alloc));

  // R4: an allocation never picks a locked way
  a_r4_victim_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    lk_alloc |-> !way_lock[lk_way]);

  // R5: global lock forbids allocation
  a_r5_glock_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CFG_GLOCK] |-> !lk_alloc);

  // R8: one cycle after the clearing edge nothing can hit
  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[CFG_FLUSH]) |=> ##1 !lk_hit);

  // R10: test mode suppresses lookups
  a_r10_test_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[CFG_TEST] |-> (!lk_hit && !lk_alloc));
endmodule

bind cache_tag_ctrl ctl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .lk_hit    (lk_hit),
  .lk_way    (lk_way),
  .lk_alloc  (lk_alloc),
  .way_lock  (set_lock)
);

// File: tb/cache_tag_ctrl_bench.sv
`timescale 1ns/1ps
module cache_tag_ctrl_bench;
  localparam int NS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_addr = '0;
  logic        fill_strobe = 1'b0;
  logic        lk_hit, lk_way, lk_alloc;
  logic        tst_we = 1'b0;
  logic [3:0]  tst_set = '0;
  logic        tst_way = 1'b0;
  logic [7:0]  tst_wtag = '0;
  logic        tst_wlock = 1'b0;
  logic [10:0] tst_rdata;

  always #4 clk = ~clk;

  cache_tag_ctrl u_cache_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .fill_strobe(fill_strobe), .lk_hit(lk_hit), .lk_way(lk_way),
    .lk_alloc(lk_alloc), .tst_we(tst_we), .tst_set(tst_set),
    .tst_way(tst_way), .tst_wtag(tst_wtag), .tst_wlock(tst_wlock),
    .tst_rdata(tst_rdata)
  );

  // behavioural reference state
  int m_vld [NS][2];
  int m_lck [NS][2];
  int m_tag [NS][2];
  int m_lru [NS];
  int m_en, m_tm, m_ll, m_gl, m_flp;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [31:0] rs = 32'h1234_5678;

  task automatic cmp(input string what, input int act, input int exp, input string req);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s at %0t: actual=%0h expected=%0h", req, what, $time, act, exp);
    end
  endtask

  // one clock: compare before the edge, advance the model at the edge
  task automatic step(input string req);
    int s, t, hw, vw, ok, e_hit, e_alloc, e_way, e_cfg, e_tr, act;
    #3;
    s  = (int'(lk_addr) >> 4) & (NS-1);
    t  = int'(lk_addr) >> 8;
    act = m_en && !m_tm;
    hw = -1;
    if (m_vld[s][0] != 0 && m_tag[s][0] == t) hw = 0;
    else if (m_vld[s][1] != 0 && m_tag[s][1] == t) hw = 1;
    ok = (m_gl == 0) && !(m_lck[s][0] != 0 && m_lck[s][1] != 0);
    vw = (m_lck[s][0] != 0) ? 1 : ((m_lck[s][1] != 0) ? 0 : m_lru[s]);
    e_hit   = (lk_valid && act && hw >= 0) ? 1 : 0;
    e_alloc = (lk_valid && act && hw < 0 && ok) ? 1 : 0;
    e_way   = e_hit ? hw : (e_alloc ? vw : 0);
    e_cfg   = (m_gl << 3) | (m_ll << 2) | (m_tm << 1) | m_en;
    e_tr    = (m_vld[tst_set][tst_way] << 10) | (m_lru[tst_set] << 9) |
              (m_lck[tst_set][tst_way] << 8) | m_tag[tst_set][tst_way];
    vectors++;
    cmp("lk_hit",    int'(lk_hit),    e_hit,   req);
    cmp("lk_alloc",  int'(lk_alloc),  e_alloc, req);
    cmp("lk_way",    int'(lk_way),    e_way,   req);
    cmp("cfg_rdata", int'(cfg_rdata), e_cfg,   req);
    cmp("tst_rdata", int'(tst_rdata), e_tr,    req);
    @(posedge clk);
    if (m_flp != 0) begin
      for (int i = 0; i < NS; i++) begin
        m_lru[i] = 0;
        for (int w = 0; w < 2; w++) begin m_vld[i][w] = 0; m_lck[i][w] = 0; end
      end
    end else begin
      if (e_alloc && fill_strobe) begin
        m_vld[s][vw] = 1; m_tag[s][vw] = t; m_lck[s][vw] = m_ll; m_lru[s] = 1 - vw;
      end
      if (e_hit) m_lru[s] = 1 - hw;
      if (m_tm != 0 && tst_we) begin
        m_tag[tst_set][tst_way] = int'(tst_wtag);
        m_lck[tst_set][tst_way] = int'(tst_wlock);
      end
    end
    m_flp = (cfg_we && cfg_wdata[4]) ? 1 : 0;
    if (cfg_we) begin
      m_en = cfg_wdata[0]; m_tm = cfg_wdata[1]; m_ll = cfg_wdata[2]; m_gl = cfg_wdata[3];
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    cfg_we = 1'b0; lk_valid = 1'b0; fill_strobe = 1'b0; tst_we = 1'b0;
  endtask

  task automatic do_idle(input string req);
    quiet(); step(req);
  endtask

  task automatic do_cfg(input logic [4:0] d, input string req);
    quiet(); cfg_we = 1'b1; cfg_wdata = d; step(req);
  endtask

  task automatic do_lookup(input logic [15:0] a, input logic f, input string req);
    quiet(); lk_valid = 1'b1; lk_addr = a; fill_strobe = f; step(req);
  endtask

  task automatic do_tread(input int s, input int w, input string req);
    quiet(); tst_set = 4'(s); tst_way = w[0]; step(req);
  endtask

  task automatic do_tw(input int s, input int w, input logic [7:0] tg, input logic lk,
                       input string req);
    quiet(); tst_we = 1'b1; tst_set = 4'(s); tst_way = w[0];
    tst_wtag = tg; tst_wlock = lk; step(req);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] x;
    x = v ^ (v << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_lru[i] = 0;
      for (int w = 0; w < 2; w++) begin m_vld[i][w] = 0; m_lck[i][w] = 0; m_tag[i][w] = 0; end
    end
    m_en = 0; m_tm = 0; m_ll = 0; m_gl = 0; m_flp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and disabled behaviour
    repeat (3) do_idle("R1");
    do_lookup(16'h0120, 1'b1, "R1");
    do_lookup(16'h0120, 1'b0, "R1");
    do_tread(2, 0, "R1");
    // R2: enable plus flush, flush field reads 0
    do_cfg(5'b10001, "R2");
    do_idle("R2");
    // R4/R3/R7: fills, hits, LRU-driven replacement
    do_lookup(16'h0120, 1'b1, "R4");
    do_lookup(16'h0120, 1'b0, "R3");
    do_lookup(16'h0220, 1'b1, "R4");
    do_lookup(16'h0220, 1'b0, "R3");
    do_lookup(16'h0320, 1'b1, "R7");
    do_lookup(16'h0120, 1'b0, "R7");
    do_tread(2, 0, "R7");
    // R6/R5: line-lock mode fills a set completely
    do_cfg(5'b00101, "R6");
    do_lookup(16'h0530, 1'b1, "R6");
    do_lookup(16'h0630, 1'b1, "R6");
    do_cfg(5'b00001, "R6");
    do_tread(3, 0, "R6");
    do_lookup(16'h0730, 1'b1, "R5");
    do_lookup(16'h0730, 1'b0, "R5");
    // R4: one locked way leaves only the other
    do_cfg(5'b00101, "R4");
    do_lookup(16'h0140, 1'b1, "R4");
    do_cfg(5'b00001, "R4");
    do_lookup(16'h0240, 1'b1, "R4");
    do_lookup(16'h0340, 1'b1, "R4");
    do_lookup(16'h0340, 1'b0, "R3");
    // R5: global lock
    do_cfg(5'b01001, "R5");
    do_lookup(16'h0950, 1'b1, "R5");
    do_lookup(16'h0950, 1'b0, "R5");
    do_lookup(16'h0340, 1'b0, "R3");
    do_cfg(5'b00001, "R5");
    // R10/R9: test mode
    do_cfg(5'b00011, "R10");
    do_lookup(16'h0340, 1'b1, "R10");
    do_lookup(16'h0860, 1'b1, "R10");
    do_tw(4, 1, 8'hAB, 1'b1, "R9");
    do_tread(4, 1, "R9");
    do_tw(6, 0, 8'h5C, 1'b0, "R9");
    do_tread(6, 0, "R9");
    do_cfg(5'b00001, "R9");
    do_tw(4, 1, 8'h11, 1'b0, "R9");
    do_tread(4, 1, "R9");
    do_lookup(16'hAB40, 1'b0, "R3");
    // R8: flush
    do_cfg(5'b10001, "R8");
    do_lookup(16'hAB40, 1'b1, "R8");
    do_lookup(16'hAB40, 1'b0, "R8");
    do_tread(4, 1, "R8");
    do_tread(3, 0, "R8");
    // mixed traffic against the model (R3 R4 R5 R6 R7 R8 R9 R10)
    for (int n = 0; n < 6000; n++) begin
      rs = nxt(rs);
      if (rs[5:0] == 6'd0) begin
        logic [4:0] d;
        d[0] = (rs[9:8] != 2'b00);
        d[1] = (rs[12:10] == 3'd0);
        d[2] = rs[13] & rs[14];
        d[3] = (rs[17:15] == 3'd0);
        d[4] = (rs[19:18] == 2'b00);
        do_cfg(d, "R2");
      end else if (rs[5:0] < 6'd6) begin
        do_tw(int'(rs[9:8]), int'(rs[10]), {6'd0, rs[12:11]}, rs[13], "R9");
      end else begin
        tst_set = {2'b00, rs[27:26]}; tst_way = rs[28];
        do_lookup({6'd0, rs[11:10], 2'b00, rs[13:12], rs[17:14]}, rs[18], "R3/R4");
      end
    end
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule